// File: doc/BRIEF.md
# Nibble-Accessed Auto-Reload Timer

This block is an 8-bit up-counter that sits on a 4-bit processor data bus. Software places the reload value through two nibble writes, low half first and then high half. The high-half write copies the assembled byte into the counter and into the reload register in the same edge. While the clock-enable `tick` input is high, the counter advances by one per clock. When it steps past 0xFF, it takes the reload value instead of wrapping to zero, and it emits a one-cycle overflow pulse that feeds a timer interrupt flag elsewhere. Counting depends only on `tick`, so the timer keeps running while the processor is halted, and its overflow can wake the processor.

Software reads the running count as two nibbles, high half first. The high-half read captures the low half into a latch. The later low-half read returns that captured value, so the two halves always belong to the same count value, even if the counter carries between the two reads.

Top module: `nibble_reload_timer`

## Requirements
- R1: Reset is synchronous and active high. It clears the counter, the reload register, the low-write holding register and the read latch to zero, and holds `ovf_pulse` low.
- R2: A cycle with `wr_hi` high loads both the counter and the reload register with {`wdata`, holding register} at that clock edge. The holding register value used here is the one present before any `wr_lo` in the same cycle.
- R3: A cycle with `wr_lo` high and `wr_hi` low only stores `wdata` in the holding register. Neither the count nor the value reloaded on a later overflow changes.
- R4: With `tick` high and no rollover or high write, the count rises by one at the clock edge. With `tick` low and no high write, the count holds.
- R5: A cycle with `tick` high, a count of 0xFF and `wr_hi` low loads the counter from the reload register.
- R6: `ovf_pulse` is high in the cycle after each edge at which `tick` was high with a count of 0xFF. At all other times it is low, so back-to-back rollovers give one pulse per rollover.
- R7: While `rd_hi` is high, `rdata` shows count bits [7:4] in the same cycle, and the edge captures count bits [3:0] into the read latch. While `rd_lo` is high and `rd_hi` is low, `rdata` shows the read latch. With neither strobe high, `rdata` is 0.
- R8: When a high write and a rollover fall in the same cycle, the written value is loaded into the counter, and `ovf_pulse` still rises in the next cycle.
- R9: Read strobes have no effect on the count or on the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one step per cycle while high |
| wdata | input | 4 | Write data nibble |
| wr_lo | input | 1 | Write strobe for the low reload half (holding register) |
| wr_hi | input | 1 | Write strobe for the high reload half; commits the full byte |
| rd_lo | input | 1 | Read strobe for the latched low count half |
| rd_hi | input | 1 | Read strobe for the high count half; captures the low half |
| rdata | output | 4 | Read data nibble |
| ovf_pulse | output | 1 | One-cycle pulse after each rollover |

## Verification
Several properties are checked on every cycle:
- the reload on rollover;
- the byte committed by a high write;
- the count holding still when idle or when only the low half is written;
- the overflow pulse timing in both directions;
- the capture into the read latch;
- the reset state.

Some behaviour shows only in the bench scenarios. These are the ordering effects across several accesses: a low half written but never committed does not reach a later reload, the latched low half stays consistent when a carry falls between the two reads, and a high write in a rollover cycle still gives the pulse.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
    localparam int NIB_W = 4;
    localparam int CNT_W = 2 * NIB_W;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CNT_W-1:0] cnt_t;

    // Direct-load command from the write side to the counter.
    typedef struct packed {
        logic en;
        cnt_t val;
    } load_cmd_t;

    localparam cnt_t CNT_TOP = {CNT_W{1'b1}};

    function automatic logic is_top(input cnt_t c);
        return c == CNT_TOP;
    endfunction

    function automatic nib_t hi_half(input cnt_t c);
        return c[CNT_W-1:NIB_W];
    endfunction

    function automatic nib_t lo_half(input cnt_t c);
        return c[NIB_W-1:0];
    endfunction
endpackage

// File: rtl/nrt_load_regs.sv
module nrt_load_regs
    import nrt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  nib_t      wdata,
    input  logic      wr_lo,
    input  logic      wr_hi,
    output load_cmd_t load_cmd,
    output cnt_t      reload_q,
    output nib_t      hold_q
);
    cnt_t assembled;

    assign assembled     = {wdata, hold_q};
    assign load_cmd.en   = wr_hi;
    assign load_cmd.val  = assembled;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            reload_q <= '0;
        end else begin
            if (wr_lo) hold_q <= wdata;
            if (wr_hi) reload_q <= assembled;
        end
    end
endmodule

// File: rtl/nrt_counter.sv
module nrt_counter
    import nrt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  load_cmd_t load_cmd,
    input  cnt_t      reload_q,
    output cnt_t      count_q,
    output logic      ovf_q
);
    logic wrap;
    cnt_t count_d;

    assign wrap = tick && is_top(count_q);

    always_comb begin
        if (load_cmd.en)   count_d = load_cmd.val;   // software write wins
        else if (wrap)     count_d = reload_q;
        else if (tick)     count_d = count_q + cnt_t'(1);
        else               count_d = count_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            ovf_q   <= wrap;
        end
    end
endmodule

// File: rtl/nrt_read_port.sv
module nrt_read_port
    import nrt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_lo,
    input  logic rd_hi,
    input  cnt_t count_q,
    output nib_t rdata,
    output nib_t lat_q
);
    always_ff @(posedge clk) begin
        if (rst)        lat_q <= '0;
        else if (rd_hi) lat_q <= lo_half(count_q);
    end

    always_comb begin
        if (rd_hi)      rdata = hi_half(count_q);
        else if (rd_lo) rdata = lat_q;
        else            rdata = '0;
    end
endmodule

// File: rtl/nibble_reload_timer.sv
module nibble_reload_timer
    import nrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [NIB_W-1:0] wdata,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             rd_lo,
    input  logic             rd_hi,
    output logic [NIB_W-1:0] rdata,
    output logic             ovf_pulse
);
    load_cmd_t load_cmd;
    cnt_t      reload_q;
    cnt_t      count_q;
    nib_t      hold_q;
    nib_t      lat_q;

    nrt_load_regs i_load (
        .clk(clk), .rst(rst), .wdata(wdata), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .load_cmd(load_cmd), .reload_q(reload_q), .hold_q(hold_q)
    );

    nrt_counter i_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load_cmd(load_cmd),
        .reload_q(reload_q), .count_q(count_q), .ovf_q(ovf_pulse)
    );

    nrt_read_port i_rd (
        .clk(clk), .rst(rst), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .count_q(count_q), .rdata(rdata), .lat_q(lat_q)
    );
endmodule

// File: rtl/nrt_timer_chk.sv
module nrt_timer_chk
    import nrt_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic tick,
    input nib_t wdata,
    input logic wr_lo,
    input logic wr_hi,
    input logic rd_hi,
    input logic ovf_pulse,
    input cnt_t count_q,
    input cnt_t reload_q,
    input nib_t hold_q,
    input nib_t lat_q
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count_q == '0 && reload_q == '0 && hold_q == '0 && lat_q == '0 && !ovf_pulse));

    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (count_q == {$past(wdata), $past(hold_q)} && reload_q == count_q));

    // R3
    lo_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi && !tick) |=> ($stable(count_q) && $stable(reload_q)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_hi) |=> $stable(count_q));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == CNT_TOP && !wr_hi) |=> (count_q == $past(reload_q)));

    // R6
    ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == CNT_TOP) |=> ovf_pulse);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick && count_q == CNT_TOP) |=> !ovf_pulse);

    // R7
    latch_capture_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hi |=> (lat_q == $past(count_q[NIB_W-1:0])));
endmodule

bind nibble_reload_timer nrt_timer_chk i_chk (
    .clk(clk), .rst(rst), .tick(tick), .wdata(wdata), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .rd_hi(rd_hi), .ovf_pulse(ovf_pulse), .count_q(count_q),
    .reload_q(reload_q), .hold_q(hold_q), .lat_q(lat_q)
);

// File: tb/test_nibble_reload_timer.sv
module test_nibble_reload_timer;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst = 1'b1;
    logic       tick = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       ovf_pulse;

    nibble_reload_timer i_nibble_reload_timer (
        .clk(clk), .rst(rst), .tick(tick), .wdata(wdata), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi), .rdata(rdata),
        .ovf_pulse(ovf_pulse)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] q_val[$];
    string      q_tag[$];

    // Reference state derived from the requirements.
    logic [7:0] m_cnt = '0, m_load = '0;
    logic [3:0] m_hold = '0, m_lat = '0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, queues the expected read data.
    task automatic step(input logic t, input logic wl, input logic wh,
                        input logic rl, input logic rh, input logic [3:0] d,
                        input string tag);
        logic [7:0] old;
        logic       ovf_e;
        tick = t; wr_lo = wl; wr_hi = wh; rd_lo = rl; rd_hi = rh; wdata = d;
        if (rh) begin q_val.push_back(m_cnt[7:4]); q_tag.push_back(tag); end
        else if (rl) begin q_val.push_back(m_lat); q_tag.push_back(tag); end
        old   = m_cnt;
        ovf_e = t && (old == 8'hFF);
        if (wh) begin m_cnt = {d, m_hold}; m_load = {d, m_hold}; end
        else if (ovf_e) m_cnt = m_load;
        else if (t) m_cnt = old + 8'd1;
        if (wl) m_hold = d;
        if (rh) m_lat = old[3:0];
        @(negedge clk);
        // R6 pulse follows each rollover edge
        check("R6", {7'd0, ovf_pulse}, {7'd0, ovf_e});
    endtask

    task automatic read_pair(input string tag);
        step(0, 0, 0, 0, 1, 4'h0, tag);
        step(0, 0, 0, 1, 0, 4'h0, tag);
    endtask

    task automatic load_byte(input logic [7:0] v, input string tag);
        step(0, 1, 0, 0, 0, v[3:0], tag);
        step(0, 0, 1, 0, 0, v[7:4], tag);
    endtask

    // Monitor: pops expected read data when a strobe is seen.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && (rd_hi || rd_lo)) begin
                if (q_val.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R7 actual=%0h expected=<none>", rdata);
                end else begin
                    check(q_tag.pop_front(), {4'd0, rdata}, {4'd0, q_val.pop_front()});
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", {7'd0, ovf_pulse}, 8'd0);
        check("R1", {4'd0, rdata}, 8'd0);
        read_pair("R1");

        // R3 low write alone leaves the count
        step(0, 1, 0, 0, 0, 4'h5, "R3");
        read_pair("R3");
        // R2 high write commits the byte
        step(0, 0, 1, 0, 0, 4'hA, "R2");
        read_pair("R2");

        // R4 increments and holds
        load_byte(8'h2E, "R4");
        step(1, 0, 0, 0, 0, 4'h0, "R4");
        step(1, 0, 0, 0, 0, 4'h0, "R4");
        repeat (3) step(0, 0, 0, 0, 0, 4'h0, "R4");
        read_pair("R4");

        // R5 reload on rollover
        load_byte(8'hFD, "R5");
        repeat (3) step(1, 0, 0, 0, 0, 4'h0, "R5");
        read_pair("R5");

        // R3 uncommitted low half does not reach the reload
        step(0, 1, 0, 0, 0, 4'h3, "R3");
        repeat (3) step(1, 0, 0, 0, 0, 4'h0, "R3");
        read_pair("R3");

        // R7 latched low half survives a carry between reads
        load_byte(8'h2F, "R7");
        step(0, 0, 0, 0, 1, 4'h0, "R7");
        step(1, 0, 0, 0, 0, 4'h0, "R7");
        step(0, 0, 0, 1, 0, 4'h0, "R7");
        step(1, 0, 0, 0, 1, 4'h0, "R7");
        step(1, 0, 0, 1, 0, 4'h0, "R7");
        read_pair("R7");

        // R8 high write and rollover together
        load_byte(8'hFF, "R8");
        step(0, 1, 0, 0, 0, 4'h1, "R8");
        step(1, 0, 1, 0, 0, 4'h4, "R8");
        read_pair("R8");

        // R6 back-to-back rollovers with reload 0xFF
        load_byte(8'hFF, "R6");
        repeat (3) step(1, 0, 0, 0, 0, 4'h0, "R6");
        read_pair("R6");

        // R9 repeated reads leave count and reload alone
        load_byte(8'hFE, "R9");
        repeat (4) read_pair("R9");
        repeat (3) step(1, 0, 0, 0, 0, 4'h0, "R9");
        read_pair("R9");

        step(0, 0, 0, 0, 0, 4'h0, "idle");
        if (q_val.size() != 0) begin
            checks++; fails++;
            $display("FAIL R7 actual=%0d expected=0 pending reads", q_val.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule